// File: doc/BRIEF.md
# Data-Space Access Router for an 8-bit Core

This block sits between the load/store path of a small 8-bit processor core and the targets behind its single flat byte address space. It takes one access at a time. It classifies the address and forwards the access to one of five destinations: the general register file, a bank of special registers kept inside this block, the status flag port, the external I/O bus, or data memory. Direct port accesses, as issued by dedicated port-in and port-out instructions, arrive with a flag set and carry the port number directly. Data-space accesses to the I/O window have the window base subtracted to form the port number.

The block owns five extended-address page registers and the stack pointer. Each page register keeps one byte and presents it in bits 23:16 of a 24-bit address extension, with the lower bits zero. The stack pointer is 16 bits wide. Four of the page registers, and the stack-pointer high byte, accept writes only when the matching configuration parameter is set. The fifth page register, which extends indirect jump targets, is always writable.

A control state machine handles the sequencing:
- `ST_IDLE` accepts a request. It moves to `ST_ISSUE` for an internal target (register file, special registers or status port) and to `ST_WAIT_EXT` for the external I/O bus or data memory.
- `ST_ISSUE` lasts exactly one cycle and returns to `ST_IDLE`.
- `ST_WAIT_EXT` holds the request until the target acknowledges, then returns to `ST_IDLE`.

Read data from every target passes through one response multiplexer, which is steered by the registered decode result.

Top module: `dspace_decoder`

## Requirements
- R1: Addresses 0 to 31 (data-space mode) raise `rf_req` with `rf_idx` equal to the address, for exactly one cycle. The response arrives in that same cycle, carrying `rf_rdata` on reads.
- R2: Data-space addresses 32 to 95 address I/O port (address − 32). In direct port mode (`acc_io`=1) the port is `acc_addr[5:0]`. Either way, non-special ports appear on `xio_port`.
- R3: Data-space addresses 96 and above raise `mem_req` with `mem_addr` equal to the full address. Request, address and data are held until `mem_ack`, and the response arrives in the acknowledge cycle.
- R4: Ports 0x38, 0x39, 0x3A and 0x3B are page registers D, X, Y and Z. A write to one of them takes effect only if bit 0, 1, 2 or 3 (in that order) of `PAGE_EN` is set; otherwise the write leaves the register unchanged.
- R5: Port 0x3C is the jump page register and is always writable. Every page register outputs its byte in bits 23:16 with bits 15:0 zero, and a read of its port returns that byte. All page registers reset to zero.
- R6: Port 0x3D reads and writes `sp_o[7:0]`.
- R7: Port 0x3E reads `sp_o[15:8]`. A write to it takes effect only when `SP_WIDE`=1.
- R8: Port 0x3F raises `st_req` with `st_we` and `st_wdata`, and a read returns `st_rdata`.
- R9: All I/O ports other than 0x38 to 0x3F raise `xio_req`. Request, port and data are held until `xio_ack`, and a read returns `xio_rdata` in the acknowledge cycle.
- R10: Only bits 7:0 of `acc_wdata` reach any target or register.
- R11: `acc_ready` is high only in the idle state. An accepted access gives exactly one `rsp_valid` pulse: one cycle after acceptance for internal targets, and in the acknowledge cycle for external ones. At most one target request is active at a time.
- R12: After reset, `acc_ready`=1, no target request is active, page registers read zero and `sp_o` equals `SP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_io | input | 1 | 1 = direct port access, address is the port number |
| acc_addr | input | AW | Data-space address or port number |
| acc_wdata | input | DW | Store data; only bits 7:0 are used |
| acc_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 8 | Load data, valid with rsp_valid on reads |
| rf_req | output | 1 | Register file access |
| rf_we | output | 1 | Register file write |
| rf_idx | output | 5 | Register index |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data |
| st_req | output | 1 | Status port access |
| st_we | output | 1 | Status port write |
| st_wdata | output | 8 | Status write data |
| st_rdata | input | 8 | Status read data |
| xio_req | output | 1 | External I/O access |
| xio_we | output | 1 | External I/O write |
| xio_port | output | 6 | External I/O port number |
| xio_wdata | output | 8 | External I/O write data |
| xio_rdata | input | 8 | External I/O read data |
| xio_ack | input | 1 | External I/O acknowledge |
| mem_req | output | 1 | Data memory access |
| mem_we | output | 1 | Data memory write |
| mem_addr | output | AW | Data memory address |
| mem_wdata | output | 8 | Data memory write data |
| mem_rdata | input | 8 | Data memory read data |
| mem_ack | input | 1 | Data memory acknowledge |
| page_d_o | output | 24 | Page register D extension |
| page_x_o | output | 24 | Page register X extension |
| page_y_o | output | 24 | Page register Y extension |
| page_z_o | output | 24 | Page register Z extension |
| jump_page_o | output | 24 | Jump page extension |
| sp_o | output | 16 | Stack pointer |

## Verification
A wrong registered decode shows up at the target ports in the first cycle after acceptance: a request appears on the wrong bus, or the index, port or address is wrong. The same decode steers the response multiplexer, so the load data returned in that cycle is also wrong. A corrupted page or stack-pointer register shows up on its output pins one cycle after the offending write. If the state machine is stuck, `acc_ready` stays low or `rsp_valid` never pulses, and the next access cannot start.

// File: rtl/ds_pkg.sv
package ds_pkg;

    typedef enum logic [2:0] {
        TGT_RF,
        TGT_CORE,
        TGT_STAT,
        TGT_XIO,
        TGT_MEM
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_EXT
    } st_e;

    // Special port numbers; the decode depends on them
    localparam int unsigned PORT_PAGE_BASE = 56;  // 0x38, first page register
    localparam int unsigned PAGE_COUNT     = 5;   // four gated pages + jump page
    localparam int unsigned PORT_SP_LO     = 61;  // 0x3D
    localparam int unsigned PORT_SP_HI     = 62;  // 0x3E
    localparam int unsigned PORT_FLAGS     = 63;  // 0x3F

endpackage

// File: rtl/ds_addr_classify.sv
module ds_addr_classify
    import ds_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned RF_COUNT = 32,
    parameter int unsigned IO_COUNT = 64,
    localparam int unsigned RW      = $clog2(RF_COUNT),
    localparam int unsigned PW      = $clog2(IO_COUNT)
) (
    input  logic [AW-1:0] addr,
    input  logic          is_io,
    output tgt_e          tgt,
    output logic [PW-1:0] port,
    output logic [RW-1:0] rf_idx
);

    localparam logic [AW-1:0] RF_END = AW'(RF_COUNT);
    localparam logic [AW-1:0] IO_END = AW'(RF_COUNT + IO_COUNT);

    logic [AW-1:0] io_off;
    logic          io_hit;

    assign io_off = addr - RF_END;
    assign rf_idx = addr[RW-1:0];

    always_comb begin
        tgt    = TGT_MEM;
        port   = '0;
        io_hit = 1'b0;
        if (is_io) begin
            io_hit = 1'b1;
            port   = addr[PW-1:0];
        end else if (addr < RF_END) begin
            tgt = TGT_RF;
        end else if (addr < IO_END) begin
            io_hit = 1'b1;
            port   = io_off[PW-1:0];
        end
        if (io_hit) begin
            if (port == PW'(PORT_FLAGS)) begin
                tgt = TGT_STAT;
            end else if (port >= PW'(PORT_PAGE_BASE)) begin
                tgt = TGT_CORE;
            end else begin
                tgt = TGT_XIO;
            end
        end
    end

endmodule

// File: rtl/ds_core_regs.sv
module ds_core_regs
    import ds_pkg::*;
#(
    parameter logic [3:0]  PAGE_EN = 4'hF,
    parameter bit          SP_WIDE = 1'b1,
    parameter logic [15:0] SP_INIT = 16'h0000,
    parameter int unsigned PW      = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PW-1:0]               port,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rd_data,
    output logic [PAGE_COUNT-1:0][23:0] page_o,
    output logic [15:0]                 sp_o
);

    localparam logic [PAGE_COUNT-1:0] WR_MASK = {1'b1, PAGE_EN};

    logic [PAGE_COUNT-1:0][7:0] page_q;
    logic [7:0]                 sp_lo_q;
    logic [7:0]                 sp_hi_q;

    for (genvar g = 0; g < PAGE_COUNT; g++) begin : g_page
        if (WR_MASK[g]) begin : g_wr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    page_q[g] <= 8'h00;
                end else if (wr_en && port == PW'(PORT_PAGE_BASE + g)) begin
                    page_q[g] <= wdata;
                end
            end
        end else begin : g_ro
            assign page_q[g] = 8'h00;
        end
        assign page_o[g] = {page_q[g], 16'h0000};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_lo_q <= SP_INIT[7:0];
        end else if (wr_en && port == PW'(PORT_SP_LO)) begin
            sp_lo_q <= wdata;
        end
    end

    if (SP_WIDE) begin : g_sp_wide
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sp_hi_q <= SP_INIT[15:8];
            end else if (wr_en && port == PW'(PORT_SP_HI)) begin
                sp_hi_q <= wdata;
            end
        end
    end else begin : g_sp_narrow
        assign sp_hi_q = SP_INIT[15:8];
    end

    assign sp_o = {sp_hi_q, sp_lo_q};

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < PAGE_COUNT; i++) begin
            if (port == PW'(PORT_PAGE_BASE + i)) rd_data = page_q[i];
        end
        if (port == PW'(PORT_SP_LO)) rd_data = sp_lo_q;
        if (port == PW'(PORT_SP_HI)) rd_data = sp_hi_q;
    end

    // R6: a low stack-pointer write is visible on the pins one cycle later
    p_splo_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == PW'(PORT_SP_LO)) |=> (sp_o[7:0] == $past(wdata)));

    // R4: without a write strobe no page register moves
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(page_o));

endmodule

// File: rtl/ds_rsp_mux.sv
module ds_rsp_mux
    import ds_pkg::*;
(
    input  tgt_e       sel,
    input  logic [7:0] rf_rdata,
    input  logic [7:0] core_rdata,
    input  logic [7:0] st_rdata,
    input  logic [7:0] xio_rdata,
    input  logic [7:0] mem_rdata,
    output logic [7:0] rdata
);

    always_comb begin
        unique case (sel)
            TGT_RF:   rdata = rf_rdata;
            TGT_CORE: rdata = core_rdata;
            TGT_STAT: rdata = st_rdata;
            TGT_XIO:  rdata = xio_rdata;
            TGT_MEM:  rdata = mem_rdata;
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
    import ds_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned RF_COUNT = 32,
    parameter int unsigned IO_COUNT = 64,
    parameter logic [3:0]  PAGE_EN  = 4'hF,
    parameter bit          SP_WIDE  = 1'b1,
    parameter logic [15:0] SP_INIT  = 16'h0000,
    localparam int unsigned RW      = $clog2(RF_COUNT),
    localparam int unsigned PW      = $clog2(IO_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_io,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic          acc_ready,
    output logic          rsp_valid,
    output logic [7:0]    rsp_rdata,
    output logic          rf_req,
    output logic          rf_we,
    output logic [RW-1:0] rf_idx,
    output logic [7:0]    rf_wdata,
    input  logic [7:0]    rf_rdata,
    output logic          st_req,
    output logic          st_we,
    output logic [7:0]    st_wdata,
    input  logic [7:0]    st_rdata,
    output logic          xio_req,
    output logic          xio_we,
    output logic [PW-1:0] xio_port,
    output logic [7:0]    xio_wdata,
    input  logic [7:0]    xio_rdata,
    input  logic          xio_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_ack,
    output logic [23:0]   page_d_o,
    output logic [23:0]   page_x_o,
    output logic [23:0]   page_y_o,
    output logic [23:0]   page_z_o,
    output logic [23:0]   jump_page_o,
    output logic [15:0]   sp_o
);

    st_e           state_q, state_d;
    tgt_e          tgt_d, tgt_q;
    logic [PW-1:0] port_d, port_q;
    logic [RW-1:0] idx_d, idx_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    wdata_q;
    logic          we_q;
    logic          accept;
    logic          ext_ack;
    logic          core_wr;
    logic [7:0]    core_rdata;
    logic [PAGE_COUNT-1:0][23:0] page_all;
    logic          unused_wdata_hi;

    assign unused_wdata_hi = ^acc_wdata[DW-1:8];

    ds_addr_classify #(
        .AW       (AW),
        .RF_COUNT (RF_COUNT),
        .IO_COUNT (IO_COUNT)
    ) classify_i (
        .addr   (acc_addr),
        .is_io  (acc_io),
        .tgt    (tgt_d),
        .port   (port_d),
        .rf_idx (idx_d)
    );

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= TGT_RF;
            port_q  <= '0;
            idx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= 8'h00;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tgt_q   <= tgt_d;
                port_q  <= port_d;
                idx_q   <= idx_d;
                addr_q  <= acc_addr;
                wdata_q <= acc_wdata[7:0];
                we_q    <= acc_write;
            end
        end
    end

    assign accept  = (state_q == ST_IDLE) && acc_valid;
    assign ext_ack = (tgt_q == TGT_XIO) ? xio_ack : mem_ack;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_valid) begin
                    state_d = (tgt_d == TGT_XIO || tgt_d == TGT_MEM) ? ST_WAIT_EXT : ST_ISSUE;
                end
            end
            ST_ISSUE:    state_d = ST_IDLE;
            ST_WAIT_EXT: if (ext_ack) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_ready = 1'b0;
        rsp_valid = 1'b0;
        rf_req    = 1'b0;
        st_req    = 1'b0;
        xio_req   = 1'b0;
        mem_req   = 1'b0;
        core_wr   = 1'b0;
        unique case (state_q)
            ST_IDLE: acc_ready = 1'b1;
            ST_ISSUE: begin
                rsp_valid = 1'b1;
                rf_req    = (tgt_q == TGT_RF);
                st_req    = (tgt_q == TGT_STAT);
                core_wr   = (tgt_q == TGT_CORE) && we_q;
            end
            ST_WAIT_EXT: begin
                xio_req   = (tgt_q == TGT_XIO);
                mem_req   = (tgt_q == TGT_MEM);
                rsp_valid = ext_ack;
            end
            default: acc_ready = 1'b0;
        endcase
    end

    assign rf_we     = we_q;
    assign rf_idx    = idx_q;
    assign rf_wdata  = wdata_q;
    assign st_we     = we_q;
    assign st_wdata  = wdata_q;
    assign xio_we    = we_q;
    assign xio_port  = port_q;
    assign xio_wdata = wdata_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    ds_core_regs #(
        .PAGE_EN (PAGE_EN),
        .SP_WIDE (SP_WIDE),
        .SP_INIT (SP_INIT),
        .PW      (PW)
    ) core_regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (core_wr),
        .port    (port_q),
        .wdata   (wdata_q),
        .rd_data (core_rdata),
        .page_o  (page_all),
        .sp_o    (sp_o)
    );

    assign page_d_o    = page_all[0];
    assign page_x_o    = page_all[1];
    assign page_y_o    = page_all[2];
    assign page_z_o    = page_all[3];
    assign jump_page_o = page_all[4];

    ds_rsp_mux rsp_mux_i (
        .sel        (tgt_q),
        .rf_rdata   (rf_rdata),
        .core_rdata (core_rdata),
        .st_rdata   (st_rdata),
        .xio_rdata  (xio_rdata),
        .mem_rdata  (mem_rdata),
        .rdata      (rsp_rdata)
    );

    p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_req, st_req, xio_req, mem_req}));

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    p_done_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> acc_ready);

    p_rf_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |=> !rf_req);

    p_xio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xio_req && !xio_ack) |=> (xio_req && $stable(xio_port) && $stable(xio_wdata)));

    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: tb/dspace_decoder_tb_top.sv
module dspace_decoder_tb_top;

    localparam logic [3:0]  T_PAGE_EN = 4'b0101;
    localparam logic [15:0] T_SP_INIT = 16'h21FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_io = 1'b0;
    logic [15:0] acc_addr = '0, acc_wdata = '0;
    logic        acc_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        rf_req, rf_we, st_req, st_we, xio_req, xio_we, mem_req, mem_we;
    logic [4:0]  rf_idx;
    logic [5:0]  xio_port;
    logic [15:0] mem_addr;
    logic [7:0]  rf_wdata, st_wdata, xio_wdata, mem_wdata;
    logic [7:0]  rf_rdata, st_rdata, xio_rdata, mem_rdata;
    logic        xio_ack = 1'b0, mem_ack = 1'b0;
    logic [23:0] pg [5];
    logic [15:0] sp_o;

    // narrow-stack-pointer instance sharing the stimulus
    logic        n_ready, n_rsp_valid;
    logic [7:0]  n_rdata;
    logic        n_rf_req, n_rf_we, n_st_req, n_st_we, n_xio_req, n_xio_we, n_mem_req, n_mem_we;
    logic [4:0]  n_rf_idx;
    logic [5:0]  n_xio_port;
    logic [15:0] n_mem_addr;
    logic [7:0]  n_rf_wdata, n_st_wdata, n_xio_wdata, n_mem_wdata;
    logic [23:0] n_pg [5];
    logic [15:0] n_sp;

    logic [7:0] rf_m  [32];
    logic [7:0] xio_m [64];
    logic [7:0] mem_m [256];
    logic [7:0] st_m;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;

    dspace_decoder #(.PAGE_EN(T_PAGE_EN), .SP_WIDE(1'b1), .SP_INIT(T_SP_INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_io(acc_io),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ready(acc_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .st_req(st_req), .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .xio_req(xio_req), .xio_we(xio_we), .xio_port(xio_port), .xio_wdata(xio_wdata),
        .xio_rdata(xio_rdata), .xio_ack(xio_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .page_d_o(pg[0]), .page_x_o(pg[1]), .page_y_o(pg[2]), .page_z_o(pg[3]),
        .jump_page_o(pg[4]), .sp_o(sp_o));

    dspace_decoder #(.PAGE_EN(T_PAGE_EN), .SP_WIDE(1'b0), .SP_INIT(T_SP_INIT)) dut_n (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_io(acc_io),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ready(n_ready), .rsp_valid(n_rsp_valid),
        .rsp_rdata(n_rdata), .rf_req(n_rf_req), .rf_we(n_rf_we), .rf_idx(n_rf_idx),
        .rf_wdata(n_rf_wdata), .rf_rdata(rf_rdata), .st_req(n_st_req), .st_we(n_st_we),
        .st_wdata(n_st_wdata), .st_rdata(st_rdata), .xio_req(n_xio_req), .xio_we(n_xio_we),
        .xio_port(n_xio_port), .xio_wdata(n_xio_wdata), .xio_rdata(xio_rdata), .xio_ack(xio_ack),
        .mem_req(n_mem_req), .mem_we(n_mem_we), .mem_addr(n_mem_addr), .mem_wdata(n_mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .page_d_o(n_pg[0]), .page_x_o(n_pg[1]),
        .page_y_o(n_pg[2]), .page_z_o(n_pg[3]), .jump_page_o(n_pg[4]), .sp_o(n_sp));

    // target models
    assign rf_rdata  = rf_m[rf_idx];
    assign xio_rdata = xio_m[xio_port];
    assign mem_rdata = mem_m[mem_addr[7:0]];
    assign st_rdata  = st_m;

    always @(posedge clk) begin
        xio_ack <= xio_req && !xio_ack;
        mem_ack <= mem_req && !mem_ack;
        if (rf_req && rf_we) rf_m[rf_idx] <= rf_wdata;
        if (st_req && st_we) st_m <= st_wdata;
        if (xio_req && xio_we && xio_ack) xio_m[xio_port] <= xio_wdata;
        if (mem_req && mem_we && mem_ack) mem_m[mem_addr[7:0]] <= mem_wdata;
    end

    // watchdog
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt == 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // observation of one access
    logic       o_rf, o_st, o_xio, o_mem;
    logic [4:0] o_idx;
    logic [5:0] o_port;
    logic [15:0] o_addr;
    logic [7:0] o_wd, o_rd, o_nrd;
    int         o_lat;

    task automatic access(input bit io, input bit wr, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_io = io; acc_write = wr; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        o_lat = 0;
        while (!rsp_valid && o_lat < 20) begin
            @(negedge clk);
            o_lat++;
        end
        o_rf = rf_req; o_st = st_req; o_xio = xio_req; o_mem = mem_req;
        o_idx = rf_idx; o_port = xio_port; o_addr = mem_addr; o_rd = rsp_rdata; o_nrd = n_rdata;
        o_wd = rf_req ? rf_wdata : st_req ? st_wdata : xio_req ? xio_wdata : mem_wdata;
    endtask

    initial begin
        logic [7:0] page_exp [5];
        logic [15:0] sp_exp, n_sp_exp;
        for (int i = 0; i < 5; i++) page_exp[i] = 8'h00;
        st_m = 8'h00;
        for (int i = 0; i < 32; i++) rf_m[i] = 8'h00;
        for (int i = 0; i < 64; i++) xio_m[i] = 8'h00;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        sp_exp = T_SP_INIT; n_sp_exp = T_SP_INIT;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(acc_ready == 1'b1, "R12 ready", acc_ready, 1);
        chk({rf_req, st_req, xio_req, mem_req} == 4'b0, "R12 no_req", {rf_req, st_req, xio_req, mem_req}, 0);
        chk(sp_o == T_SP_INIT, "R12 sp", sp_o, T_SP_INIT);
        for (int i = 0; i < 5; i++) chk(pg[i] == 24'h0, "R12 page", pg[i], 0);

        // R1 / R10: register file sweep
        for (int i = 0; i < 32; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 11) & 255);
            access(1'b0, 1'b1, 16'(i), {8'hA5, v});
            chk(o_rf && o_idx == 5'(i), "R1 rf_write_route", {o_rf, o_idx}, {1'b1, 5'(i)});
            chk(o_wd == v, "R10 rf_wdata_mask", o_wd, v);
            chk(o_lat == 0, "R11 rf_latency", o_lat, 0);
        end
        for (int i = 0; i < 32; i++) begin
            access(1'b0, 1'b0, 16'(i), 16'h0);
            chk(o_rd == 8'((i * 37 + 11) & 255), "R1 rf_read", o_rd, (i * 37 + 11) & 255);
        end

        // R2 / R9: external I/O sweep, data-space write, direct read
        for (int p = 0; p < 56; p++) begin
            access(1'b0, 1'b1, 16'(p + 32), {8'h3C, 8'(p ^ 8'h5A)});
            chk(o_xio && o_port == 6'(p), "R2 xio_port_data", {o_xio, o_port}, {1'b1, 6'(p)});
            chk(o_lat == 1, "R9 xio_wait_ack", o_lat, 1);
        end
        for (int p = 0; p < 56; p++) begin
            access(1'b1, 1'b0, 16'(p), 16'h0);
            chk(o_xio && o_port == 6'(p), "R2 xio_port_direct", {o_xio, o_port}, {1'b1, 6'(p)});
            chk(o_rd == 8'(p ^ 8'h5A), "R9 xio_read", o_rd, p ^ 8'h5A);
        end

        // R3: data memory
        begin
            logic [15:0] ma [4];
            ma[0] = 16'd96; ma[1] = 16'd97; ma[2] = 16'h1234; ma[3] = 16'hFFFF;
            for (int k = 0; k < 4; k++) begin
                access(1'b0, 1'b1, ma[k], {8'hFF, 8'(ma[k][7:0] + 8'h21)});
                chk(o_mem && o_addr == ma[k], "R3 mem_route", {o_mem, o_addr}, {1'b1, ma[k]});
                chk(o_wd == 8'(ma[k][7:0] + 8'h21), "R10 mem_wdata_mask", o_wd, ma[k][7:0] + 8'h21);
            end
            for (int k = 0; k < 4; k++) begin
                access(1'b0, 1'b0, ma[k], 16'h0);
                chk(o_rd == 8'(ma[k][7:0] + 8'h21), "R3 mem_read", o_rd, ma[k][7:0] + 8'h21);
                chk(o_lat == 1, "R11 mem_latency", o_lat, 1);
            end
        end

        // R4 / R5: page registers
        for (int g = 0; g < 5; g++) begin
            logic [7:0] v;
            bit en;
            v = 8'(8'h13 * (g + 1) + 8'h40);
            en = (g == 4) ? 1'b1 : T_PAGE_EN[g];
            access(1'b0, 1'b1, 16'(32 + 56 + g), {8'h77, v});
            chk({o_rf, o_st, o_xio, o_mem} == 4'b0, "R4 page_no_ext", {o_rf, o_st, o_xio, o_mem}, 0);
            if (en) page_exp[g] = v;
            @(negedge clk);
            chk(pg[g] == {page_exp[g], 16'h0}, g == 4 ? "R5 jump_page_write" : "R4 page_write_gate",
                pg[g], {page_exp[g], 16'h0});
            access(1'b1, 1'b0, 16'(56 + g), 16'h0);
            chk(o_rd == page_exp[g], "R5 page_read", o_rd, page_exp[g]);
        end

        // R6 / R7: stack pointer
        access(1'b1, 1'b1, 16'd61, 16'hEEC3);
        sp_exp[7:0] = 8'hC3; n_sp_exp[7:0] = 8'hC3;
        @(negedge clk);
        chk(sp_o == sp_exp, "R6 sp_lo_write", sp_o, sp_exp);
        chk(n_sp == n_sp_exp, "R6 sp_lo_write_narrow", n_sp, n_sp_exp);
        access(1'b0, 1'b1, 16'd94, 16'h114E);
        sp_exp[15:8] = 8'h4E;
        @(negedge clk);
        chk(sp_o == sp_exp, "R7 sp_hi_write_wide", sp_o, sp_exp);
        chk(n_sp == n_sp_exp, "R7 sp_hi_ignored_narrow", n_sp, n_sp_exp);
        access(1'b1, 1'b0, 16'd62, 16'h0);
        chk(o_rd == sp_exp[15:8], "R7 sp_hi_read", o_rd, sp_exp[15:8]);
        chk(o_nrd == n_sp_exp[15:8], "R7 sp_hi_read_narrow", o_nrd, n_sp_exp[15:8]);
        access(1'b0, 1'b0, 16'd93, 16'h0);
        chk(o_rd == sp_exp[7:0], "R6 sp_lo_read", o_rd, sp_exp[7:0]);

        // R8: status port
        access(1'b0, 1'b1, 16'd95, 16'hC09B);
        chk(o_st && o_wd == 8'h9B, "R8 status_write", {o_st, o_wd}, {1'b1, 8'h9B});
        access(1'b1, 1'b0, 16'd63, 16'h0);
        chk(o_st && o_rd == 8'h9B, "R8 status_read", {o_st, o_rd}, {1'b1, 8'h9B});

        // R11: back in idle and accepting
        @(negedge clk);
        chk(acc_ready == 1'b1 && rsp_valid == 1'b0, "R11 idle_after", {acc_ready, rsp_valid}, 2'b10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule